// File: doc/BRIEF.md
# I2C Framing Event Tagger

This block watches the (already delayed) serial data and serial clock lines of an I2C bus and recognises the two framing conditions. A start condition is the data line falling while the clock line stays high. A stop condition is the data line rising while the clock line stays high. For each condition the block raises its own condition flag. The flag is meant to be sampled by a logic analyser as a state qualifier.

After each detection, a single marker bit travels down a short chain of flip-flops. The chain advances only on cycles where the delay-clock enable is high. Decoding two neighbouring taps of the chain gives a store strobe that is exactly one delay period wide. A later tap drops the flag again. As a result, the flag is steady before the strobe, during it and at its falling edge, which is where the analyser latches. The start and stop chains are two copies of the same logic.

The strobes of both chains are merged with a data-ready strobe from a neighbouring byte-capture block into one store output. A one-cycle start pulse is also provided, so that the capture block can preset itself when a new frame begins. A start that is seen while a stop sequence is still in flight abandons that stop sequence.

Top module: `bus_event_tagger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `start_flag`, `stop_flag` and `start_pulse` are 0, and `store_strobe` follows only `byte_ready`. The line history resets to idle (both lines high).
- R2: At a clock edge where `sda_in` is sampled 0, the previous sample of `sda_in` was 1, and `scl_in` is 1 in both samples, `start_flag` becomes 1 and `start_pulse` is 1 for exactly that one cycle.
- R3: At a clock edge where `sda_in` is sampled 1, the previous sample was 0, and `scl_in` is 1 in both samples, `stop_flag` becomes 1.
- R4: A change of `sda_in` produces no event if `scl_in` is 0 in either of the two samples. This includes data changing while the clock is low, and data changing on the same edge where the clock rises.
- R5: After an event, the chain advances only on cycles with `dly_tick` = 1. The event's strobe is high after the second such tick and low again after the third. Its width is therefore one tick period, and its delay after the event is between one and two tick periods.
- R6: The event's flag stays 1 through the whole strobe. It returns to 0 on the clock edge after the fourth tick following the event.
- R7: `store_strobe` is the OR of the start strobe, the stop strobe and the `byte_ready` input, with no added latency for `byte_ready`.
- R8: A start detected while a stop sequence is pending clears `stop_flag` on that edge and discards the pending stop strobe. The start sequence then begins from its first stage.
- R9: A repeated event of the same kind during its own sequence restarts that chain. The next strobe comes two ticks after the latest event, and only one strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dly_tick | input | 1 | Delay-clock enable, one `clk` cycle per delay period |
| sda_in | input | 1 | Delayed serial data line |
| scl_in | input | 1 | Delayed serial clock line |
| byte_ready | input | 1 | Data-ready strobe from the byte-capture block |
| start_flag | output | 1 | Start condition flag |
| stop_flag | output | 1 | Stop condition flag |
| store_strobe | output | 1 | Merged store strobe for the analyser |
| start_pulse | output | 1 | One-cycle pulse on each detected start |

## Verification
A chain holding a stale or extra marker shows up at the ports within a few ticks. The symptoms are a second strobe, a strobe whose delay from the event is wrong, or a strobe whose width differs from one tick period. A flag register that is cleared too early is visible at the strobe's falling edge, where the flag must still be high. A flag that is never cleared stays high past the fourth tick. A wrong line history shows up on the very next edge, as a false or missing `start_pulse` or a wrong flag. A failed stop cancellation shows up as a stop strobe that lands two ticks after the start.

// File: rtl/tagger_pkg.sv
// Package: shared constants for the I2C framing event tagger.
// Assumes event indices are dense, starting at zero.
package tagger_pkg;
    localparam int NUM_EV   = 2;
    localparam int EV_START = 0;
    localparam int EV_STOP  = 1;
    // Which event chains a detected start aborts (bit per event index).
    localparam logic [NUM_EV-1:0] ABORTED_BY_START = 2'b10;
endpackage

// File: rtl/line_cond_detect.sv
// Module: line_cond_detect
// Keeps one-sample history of both bus lines and flags start/stop
// conditions combinationally against the current sample.
// Assumes the lines are already synchronous to clk.
module line_cond_detect
    import tagger_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic [NUM_EV-1:0] hit
);
    logic sda_prev;
    logic scl_prev;
    logic scl_held;

    // Line history, reset to the idle-high bus state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_in;
            scl_prev <= scl_in;
        end
    end

    // Clock must be high in both samples for a data change to count.
    always_comb begin
        scl_held      = scl_prev & scl_in;
        hit           = '0;
        hit[EV_START] = scl_held & sda_prev & ~sda_in;
        hit[EV_STOP]  = scl_held & ~sda_prev & sda_in;
    end
endmodule

// File: rtl/event_chain.sv
// Module: event_chain
// One condition flag plus a marker-propagation chain. A hit sets the flag
// and arms a marker; each tick shifts it one stage. Strobe = tap STROBE_TAP
// and not the next tap; flag drops once the marker reaches CLEAR_TAP.
// Assumes STROBE_TAP+1 < CLEAR_TAP < CHAIN_LEN.
module event_chain #(
    parameter int CHAIN_LEN  = 4,
    parameter int STROBE_TAP = 1,
    parameter int CLEAR_TAP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic abort,
    output logic flag,
    output logic strobe
);
    localparam int LAST = CHAIN_LEN - 1;

    logic            armed;
    logic [LAST:0]   taps;

    // Flag, arm bit and chain: hit restarts, abort empties, tick shifts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
            taps  <= '0;
        end else if (hit) begin
            flag  <= 1'b1;
            armed <= 1'b1;
            taps  <= '0;
        end else if (abort) begin
            flag  <= 1'b0;
            armed <= 1'b0;
            taps  <= '0;
        end else begin
            if (tick) begin
                taps  <= {taps[LAST-1:0], armed};
                armed <= 1'b0;
            end
            if (taps[CLEAR_TAP]) begin
                flag <= 1'b0;
            end
        end
    end

    // Adjacent-tap decode: high for exactly one tick period.
    assign strobe = taps[STROBE_TAP] & ~taps[STROBE_TAP+1];
endmodule

// File: rtl/store_merge.sv
// Module: store_merge
// Combines the per-event strobes with the external data-ready strobe.
// Assumes all sources are already one-tick-wide pulses.
module store_merge #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] ev_strobe,
    input  logic             ext_strobe,
    output logic             store
);
    // Plain OR, no register, so the external strobe keeps its timing.
    assign store = (|ev_strobe) | ext_strobe;
endmodule

// File: rtl/bus_event_tagger.sv
// Module: bus_event_tagger (top)
// Detects I2C start/stop, runs one event_chain per condition, merges the
// strobes and emits a one-cycle start pulse for the byte-capture block.
// Assumes dly_tick is a single-cycle enable from a clock divider.
module bus_event_tagger
    import tagger_pkg::*;
#(
    parameter int CHAIN_LEN  = 4,
    parameter int STROBE_TAP = 1,
    parameter int CLEAR_TAP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_tick,
    input  logic sda_in,
    input  logic scl_in,
    input  logic byte_ready,
    output logic start_flag,
    output logic stop_flag,
    output logic store_strobe,
    output logic start_pulse
);
    logic [NUM_EV-1:0] ev_hit;
    logic [NUM_EV-1:0] ev_abort;
    logic [NUM_EV-1:0] ev_flag;
    logic [NUM_EV-1:0] ev_strobe;

    line_cond_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sda_in (sda_in),
        .scl_in (scl_in),
        .hit    (ev_hit)
    );

    // One identical chain per framing condition.
    for (genvar g = 0; g < NUM_EV; g++) begin : g_chain
        assign ev_abort[g] = ABORTED_BY_START[g] & ev_hit[EV_START];

        event_chain #(
            .CHAIN_LEN  (CHAIN_LEN),
            .STROBE_TAP (STROBE_TAP),
            .CLEAR_TAP  (CLEAR_TAP)
        ) u_chain (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (dly_tick),
            .hit    (ev_hit[g]),
            .abort  (ev_abort[g]),
            .flag   (ev_flag[g]),
            .strobe (ev_strobe[g])
        );
    end

    store_merge #(.N_SRC(NUM_EV)) u_merge (
        .ev_strobe  (ev_strobe),
        .ext_strobe (byte_ready),
        .store      (store_strobe)
    );

    // Registered start pulse, aligned with the start flag rising.
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= ev_hit[EV_START];
    end

    assign start_flag = ev_flag[EV_START];
    assign stop_flag  = ev_flag[EV_STOP];
endmodule

// File: rtl/tagger_checks.sv
// Module: tagger_checks
// Port-level temporal properties of bus_event_tagger, bound to the top.
module tagger_checks (
    input logic clk,
    input logic rst_n,
    input logic sda_in,
    input logic scl_in,
    input logic byte_ready,
    input logic start_flag,
    input logic stop_flag,
    input logic store_strobe,
    input logic start_pulse
);
    // R2: start pulse lasts a single cycle
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // R2: pulse and flag appear together
    a_r2_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> start_flag);
    // R2: flag only rises on a detected start
    a_r2_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> start_pulse);
    // R3: stop flag rises only after a rising data line with clock high
    a_r3_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> ($past(sda_in) && !$past(sda_in, 2)
                              && $past(scl_in) && $past(scl_in, 2)));
    // R4: no start when the clock line is low
    a_r4_scl_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_in |=> !start_pulse);
    // R6: event strobes only occur while a flag is held
    a_r6_flag_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (store_strobe && !byte_ready) |-> (start_flag || stop_flag));
    // R8: a start leaves no stop flag behind
    a_r8_start_aborts_stop: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !stop_flag);
endmodule

bind bus_event_tagger tagger_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_in       (sda_in),
    .scl_in       (scl_in),
    .byte_ready   (byte_ready),
    .start_flag   (start_flag),
    .stop_flag    (stop_flag),
    .store_strobe (store_strobe),
    .start_pulse  (start_pulse)
);

// File: tb/bus_event_tagger_test.sv
module bus_event_tagger_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dly_tick = 1'b0;
    logic sda_in = 1'b1;
    logic scl_in = 1'b1;
    logic byte_ready = 1'b0;
    logic start_flag, stop_flag, store_strobe, start_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_event_tagger uut (
        .clk(clk), .rst_n(rst_n), .dly_tick(dly_tick), .sda_in(sda_in),
        .scl_in(scl_in), .byte_ready(byte_ready), .start_flag(start_flag),
        .stop_flag(stop_flag), .store_strobe(store_strobe),
        .start_pulse(start_pulse)
    );

    // Row: [7]scl [6]sda [5]tick [4]rdy | [3]start_flag [2]stop_flag [1]store [0]start_pulse
    localparam int NV = 25;
    localparam logic [7:0] VEC [NV] = '{
        8'b1110_0000, // 0  idle, R4
        8'b1010_1001, // 1  start, R2
        8'b1010_1000, // 2  stage 0, R5
        8'b0010_1010, // 3  strobe, R5
        8'b0110_1000, // 4  sda moves with scl low, R4
        8'b0110_1000, // 5  marker at clear stage, R6
        8'b0110_0000, // 6  flag dropped, R6
        8'b0111_0010, // 7  data-ready passes, R7
        8'b1010_0000, // 8  sda falls as scl rises, R4
        8'b1110_0100, // 9  stop, R3
        8'b1110_0100, // 10 stage 0, R5
        8'b1110_0110, // 11 strobe, R5
        8'b1110_0100, // 12 R5
        8'b1110_0100, // 13 R6
        8'b1110_0000, // 14 R6
        8'b0010_0000, // 15 R4
        8'b1010_0000, // 16 R4
        8'b1110_0100, // 17 stop, R3
        8'b1110_0100, // 18 R5
        8'b1010_1001, // 19 start aborts stop, R8
        8'b1010_1000, // 20 R8
        8'b1010_1010, // 21 start strobe only, R8
        8'b1010_1000, // 22 R5
        8'b1010_1000, // 23 R6
        8'b1010_0000  // 24 R6
    };
    localparam int VREQ [NV] = '{4,2,5,5,4,6,6,7,4,3,5,5,5,6,6,4,4,3,5,8,8,8,5,6,6};

    task automatic check(input string what, input int req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive at the current falling edge, then sample after the next rising edge.
    task automatic step(input logic c, input logic d, input logic t, input logic r);
        scl_in = c; sda_in = d; dly_tick = t; byte_ready = r;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin : main
        int scount, first;
        // R1: reset state
        @(negedge clk); step(1, 1, 1, 0); step(1, 0, 1, 0);
        check("r1_start_flag", 1, start_flag, 1'b0);
        check("r1_stop_flag", 1, stop_flag, 1'b0);
        check("r1_start_pulse", 1, start_pulse, 1'b0);
        check("r1_store", 1, store_strobe, 1'b0);
        @(negedge clk); step(1, 1, 1, 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check($sformatf("row%0d start_flag", i), VREQ[i], start_flag, VEC[i][3]);
            check($sformatf("row%0d stop_flag", i), VREQ[i], stop_flag, VEC[i][2]);
            check($sformatf("row%0d store", i), VREQ[i], store_strobe, VEC[i][1]);
            check($sformatf("row%0d start_pulse", i), VREQ[i], start_pulse, VEC[i][0]);
            @(negedge clk);
        end

        // R5/R6: slow tick, one tick every 4 clocks; strobe spans one tick period
        step(0, 1, 0, 0); @(negedge clk);
        step(1, 1, 0, 0); @(negedge clk);
        step(1, 0, 0, 0); @(negedge clk);
        scount = 0; first = 0;
        for (int k = 0; k < 24; k++) begin
            step(1, 0, (k % 4) == 0, 0);
            if (store_strobe) begin
                scount++;
                if (!start_flag) first = 1;
            end
            @(negedge clk);
        end
        check("r5_slow_strobe_width_is_4", 5, scount == 4, 1'b1);
        check("r6_flag_high_during_strobe", 6, first == 0, 1'b1);
        check("r6_flag_cleared_at_end", 6, start_flag, 1'b0);

        // R9: repeated start restarts its chain
        step(0, 1, 0, 0); @(negedge clk);
        step(1, 1, 0, 0); @(negedge clk);
        step(1, 0, 0, 0); @(negedge clk);
        step(1, 0, 1, 0); @(negedge clk);  // marker into stage 0
        step(0, 0, 0, 0); @(negedge clk);
        step(0, 1, 0, 0); @(negedge clk);
        step(1, 1, 0, 0); @(negedge clk);
        step(1, 0, 0, 0);                  // second start
        check("r9_restart_pulse", 9, start_pulse, 1'b1);
        @(negedge clk);
        scount = 0; first = -1;
        for (int k = 1; k <= 8; k++) begin
            step(1, 0, 1, 0);
            if (store_strobe) begin
                scount++;
                if (first < 0) first = k;
            end
            @(negedge clk);
        end
        check("r9_single_strobe", 9, scount == 1, 1'b1);
        check("r9_strobe_after_two_ticks", 9, first == 2, 1'b1);

        // R1: reset mid-sequence clears flags
        step(0, 0, 0, 0); @(negedge clk);
        step(1, 0, 0, 0); @(negedge clk);
        step(1, 1, 0, 0); @(negedge clk);
        rst_n = 1'b0;
        step(1, 1, 1, 0);
        check("r1_mid_reset_stop_flag", 1, stop_flag, 1'b0);
        check("r1_reset_store_follows_ready", 1, store_strobe, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule